// File: doc/BRIEF.md
# ADC End-of-Conversion Interrupt Aggregator

This block collects completion events from an analog-to-digital converter and turns them into interrupt lines. Each time the converter reports a finished conversion, it sends a one-cycle strobe with the channel index and a flag that says whether the conversion was normal or injected. The block then sets that channel's pending bit and one of two global per-conversion status flags. Two further strobes report the end of a normal chain and the end of an injected chain, and each one sets its own global status flag.

Software programs a per-channel mask and a four-bit global mask through a single write port, and clears pending and status bits by writing ones. The normal and injected per-conversion interrupts are qualified three ways. The global status flag must be set, its global mask bit must be set, and at least one channel must have both its pending bit and its channel mask bit set. The chain interrupts need only their status flag and their mask bit. One more output is the OR of the four interrupt lines.

The design has no sequencing state, so it holds no state machine. It is built from a channel bank, a global flag bank and an interrupt combiner. All of its storage is plain set/clear registers.

Top module: `eoc_irq_agg`

## Requirements
- R1: After reset, all channel pending bits, channel mask bits, global status bits and global mask bits are 0, and every interrupt output is low.
- R2: A conversion strobe with a channel index below NCH sets that channel's pending bit on the next clock edge, for both normal and injected conversions. A strobe whose index is NCH or above changes no pending bit and no status bit.
- R3: A valid conversion strobe with the injected flag low sets global status bit 0 (normal per-conversion). With the injected flag high it sets global status bit 2 (injected per-conversion). The other bit does not change.
- R4: The end-of-normal-chain strobe sets global status bit 1. The end-of-injected-chain strobe sets global status bit 3.
- R5: A write with select 1 clears every channel pending bit whose data bit is 1. A write with select 3 clears every global status bit whose data bit (bits 3:0) is 1. Bits written with 0 keep their value.
- R6: When a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R7: The normal per-conversion interrupt is high exactly when global status bit 0 and global mask bit 0 are set and at least one channel has both its pending bit and its mask bit set.
- R8: The injected per-conversion interrupt is high exactly when global status bit 2 and global mask bit 2 are set and at least one channel has both its pending bit and its mask bit set.
- R9: The normal-chain interrupt is high when status bit 1 and mask bit 1 are set. The injected-chain interrupt is high when status bit 3 and mask bit 3 are set.
- R10: The combined interrupt output is the OR of the four interrupt lines.
- R11: A write with select 0 loads the channel mask from the data. A write with select 2 loads the global mask from data bits 3:0. Both registers read back on their outputs after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | One-cycle strobe: a conversion finished |
| conv_chan_i | input | CH_W | Channel index of the finished conversion |
| conv_inj_i | input | 1 | 1 = injected conversion, 0 = normal |
| nchain_done_i | input | 1 | End of normal chain strobe |
| ichain_done_i | input | 1 | End of injected chain strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 channel mask, 1 pending clear, 2 global mask, 3 status clear |
| wr_data_i | input | NCH | Write data |
| chan_pend_o | output | NCH | Per-channel pending bits |
| chan_mask_o | output | NCH | Per-channel mask bits |
| glb_stat_o | output | 4 | Global status: 0 normal conv, 1 normal chain, 2 injected conv, 3 injected chain |
| glb_mask_o | output | 4 | Global mask, same bit order |
| irq_neoc_o | output | 1 | Normal per-conversion interrupt |
| irq_nchain_o | output | 1 | Normal-chain interrupt |
| irq_jeoc_o | output | 1 | Injected per-conversion interrupt |
| irq_jchain_o | output | 1 | Injected-chain interrupt |
| irq_any_o | output | 1 | OR of all interrupt lines |

## Verification
The hardest case to reach from the ports is a collision: a completion event and a write-one-to-clear land on the same bit in the same clock cycle. The bench reaches it by driving the conversion strobe and the clearing write together before a single edge, and then reads the pending and status bits back. It also walks the three-way qualification one condition at a time. A pending bit on an unmasked channel must not raise the per-conversion interrupt, and removing the global mask or the last qualifying pending bit must drop it again.

// File: rtl/eoc_irq_pkg.sv
package eoc_irq_pkg;

    typedef enum logic [1:0] {
        REG_CMASK = 2'd0,
        REG_CPEND = 2'd1,
        REG_GMASK = 2'd2,
        REG_GSTAT = 2'd3
    } reg_sel_e;

    localparam int unsigned GF_NEOC   = 0;
    localparam int unsigned GF_NCHAIN = 1;
    localparam int unsigned GF_JEOC   = 2;
    localparam int unsigned GF_JCHAIN = 3;
    localparam int unsigned GF_NUM    = 4;

endpackage

// File: rtl/eoc_chan_bank.sv
module eoc_chan_bank #(
    parameter int unsigned NCH  = 24,
    parameter int unsigned CH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_valid_i,
    input  logic [CH_W-1:0] set_chan_i,
    input  logic            mask_we_i,
    input  logic            clr_we_i,
    input  logic [NCH-1:0]  wdata_i,
    output logic [NCH-1:0]  pend_o,
    output logic [NCH-1:0]  mask_o,
    output logic            hit_o
);

    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] mask_q;

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        logic hit_set;
        assign hit_set = set_valid_i && (set_chan_i == CH_W'(gi));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[gi] <= 1'b0;
            end else if (hit_set) begin
                pend_q[gi] <= 1'b1;            // set has priority over clear
            end else if (clr_we_i && wdata_i[gi]) begin
                pend_q[gi] <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[gi] <= 1'b0;
            end else if (mask_we_i) begin
                mask_q[gi] <= wdata_i[gi];
            end
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign hit_o  = |(pend_q & mask_q);

endmodule

// File: rtl/eoc_glb_flags.sv
module eoc_glb_flags
    import eoc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GF_NUM-1:0] set_i,
    input  logic              mask_we_i,
    input  logic              clr_we_i,
    input  logic [GF_NUM-1:0] wdata_i,
    output logic [GF_NUM-1:0] stat_o,
    output logic [GF_NUM-1:0] mask_o
);

    logic [GF_NUM-1:0] stat_q;
    logic [GF_NUM-1:0] mask_q;

    for (genvar gi = 0; gi < GF_NUM; gi++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[gi] <= 1'b0;
            end else if (set_i[gi]) begin
                stat_q[gi] <= 1'b1;
            end else if (clr_we_i && wdata_i[gi]) begin
                stat_q[gi] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we_i) begin
            mask_q <= wdata_i;
        end
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/eoc_irq_comb.sv
module eoc_irq_comb
    import eoc_irq_pkg::*;
(
    input  logic [GF_NUM-1:0] stat_i,
    input  logic [GF_NUM-1:0] mask_i,
    input  logic              chan_hit_i,
    output logic [GF_NUM-1:0] irq_o,
    output logic              irq_any_o
);

    logic [GF_NUM-1:0] armed;

    always_comb begin
        armed = stat_i & mask_i;
        irq_o = armed;
        // per-conversion lines need a qualifying channel as well
        irq_o[GF_NEOC] = armed[GF_NEOC] && chan_hit_i;
        irq_o[GF_JEOC] = armed[GF_JEOC] && chan_hit_i;
        irq_any_o      = |irq_o;
    end

endmodule

// File: rtl/eoc_irq_agg.sv
module eoc_irq_agg
    import eoc_irq_pkg::*;
#(
    parameter  int unsigned NCH  = 24,
    localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            conv_done_i,
    input  logic [CH_W-1:0] conv_chan_i,
    input  logic            conv_inj_i,
    input  logic            nchain_done_i,
    input  logic            ichain_done_i,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_sel_i,
    input  logic [NCH-1:0]  wr_data_i,
    output logic [NCH-1:0]  chan_pend_o,
    output logic [NCH-1:0]  chan_mask_o,
    output logic [3:0]      glb_stat_o,
    output logic [3:0]      glb_mask_o,
    output logic            irq_neoc_o,
    output logic            irq_nchain_o,
    output logic            irq_jeoc_o,
    output logic            irq_jchain_o,
    output logic            irq_any_o
);

    reg_sel_e          sel;
    logic              conv_ok;
    logic [GF_NUM-1:0] gset;
    logic              chan_hit;
    logic [GF_NUM-1:0] irq_vec;

    assign sel     = reg_sel_e'(wr_sel_i);
    assign conv_ok = conv_done_i && ({1'b0, conv_chan_i} < (CH_W+1)'(NCH));

    always_comb begin
        gset            = '0;
        gset[GF_NEOC]   = conv_ok && !conv_inj_i;
        gset[GF_JEOC]   = conv_ok &&  conv_inj_i;
        gset[GF_NCHAIN] = nchain_done_i;
        gset[GF_JCHAIN] = ichain_done_i;
    end

    eoc_chan_bank #(.NCH(NCH), .CH_W(CH_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_valid_i (conv_ok),
        .set_chan_i  (conv_chan_i),
        .mask_we_i   (wr_en_i && sel == REG_CMASK),
        .clr_we_i    (wr_en_i && sel == REG_CPEND),
        .wdata_i     (wr_data_i),
        .pend_o      (chan_pend_o),
        .mask_o      (chan_mask_o),
        .hit_o       (chan_hit)
    );

    eoc_glb_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (gset),
        .mask_we_i (wr_en_i && sel == REG_GMASK),
        .clr_we_i  (wr_en_i && sel == REG_GSTAT),
        .wdata_i   (wr_data_i[GF_NUM-1:0]),
        .stat_o    (glb_stat_o),
        .mask_o    (glb_mask_o)
    );

    eoc_irq_comb u_comb (
        .stat_i     (glb_stat_o),
        .mask_i     (glb_mask_o),
        .chan_hit_i (chan_hit),
        .irq_o      (irq_vec),
        .irq_any_o  (irq_any_o)
    );

    assign irq_neoc_o   = irq_vec[GF_NEOC];
    assign irq_nchain_o = irq_vec[GF_NCHAIN];
    assign irq_jeoc_o   = irq_vec[GF_JEOC];
    assign irq_jchain_o = irq_vec[GF_JCHAIN];

endmodule

// File: rtl/eoc_irq_agg_chk.sv
module eoc_irq_agg_chk #(
    parameter  int unsigned NCH  = 24,
    localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_done_i,
    input logic [CH_W-1:0] conv_chan_i,
    input logic            conv_inj_i,
    input logic            nchain_done_i,
    input logic            ichain_done_i,
    input logic            wr_en_i,
    input logic [1:0]      wr_sel_i,
    input logic [NCH-1:0]  wr_data_i,
    input logic [NCH-1:0]  chan_pend_o,
    input logic [NCH-1:0]  chan_mask_o,
    input logic [3:0]      glb_stat_o,
    input logic [3:0]      glb_mask_o,
    input logic            irq_neoc_o,
    input logic            irq_nchain_o,
    input logic            irq_jeoc_o,
    input logic            irq_jchain_o,
    input logic            irq_any_o
);

    logic ok_idx;
    logic quiet;
    assign ok_idx = {1'b0, conv_chan_i} < (CH_W+1)'(NCH);
    assign quiet  = !conv_done_i && !nchain_done_i && !ichain_done_i;

    p_chan_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && ok_idx) |=> chan_pend_o[$past(conv_chan_i)]);

    p_neoc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && ok_idx && !conv_inj_i) |=> glb_stat_o[0]);

    p_jeoc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && ok_idx && conv_inj_i) |=> glb_stat_o[2]);

    p_chain_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nchain_done_i && ichain_done_i) |=> (glb_stat_o[1] && glb_stat_o[3]));

    p_stat_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd3 && quiet) |=> ((glb_stat_o & $past(wr_data_i[3:0])) == 4'd0));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && quiet) |=> ($stable(glb_stat_o) && $stable(chan_pend_o)));

    p_neoc_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_neoc_o |-> (glb_stat_o[0] && glb_mask_o[0] && (|(chan_pend_o & chan_mask_o))));

    p_jeoc_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_jeoc_o |-> (glb_stat_o[2] && glb_mask_o[2] && (|(chan_pend_o & chan_mask_o))));

    p_chain_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_nchain_o |-> glb_mask_o[1]) and (irq_jchain_o |-> glb_mask_o[3]));

    p_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any_o == (irq_neoc_o || irq_nchain_o || irq_jeoc_o || irq_jchain_o));

endmodule

bind eoc_irq_agg eoc_irq_agg_chk #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .conv_done_i   (conv_done_i),
    .conv_chan_i   (conv_chan_i),
    .conv_inj_i    (conv_inj_i),
    .nchain_done_i (nchain_done_i),
    .ichain_done_i (ichain_done_i),
    .wr_en_i       (wr_en_i),
    .wr_sel_i      (wr_sel_i),
    .wr_data_i     (wr_data_i),
    .chan_pend_o   (chan_pend_o),
    .chan_mask_o   (chan_mask_o),
    .glb_stat_o    (glb_stat_o),
    .glb_mask_o    (glb_mask_o),
    .irq_neoc_o    (irq_neoc_o),
    .irq_nchain_o  (irq_nchain_o),
    .irq_jeoc_o    (irq_jeoc_o),
    .irq_jchain_o  (irq_jchain_o),
    .irq_any_o     (irq_any_o)
);

// File: tb/eoc_irq_agg_tb_top.sv
module eoc_irq_agg_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NCH  = 24;
    localparam int unsigned CH_W = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            conv_done = 1'b0;
    logic [CH_W-1:0] conv_chan = '0;
    logic            conv_inj = 1'b0;
    logic            nchain = 1'b0;
    logic            ichain = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_sel = 2'd0;
    logic [NCH-1:0]  wr_data = '0;
    logic [NCH-1:0]  pend, cmask;
    logic [3:0]      gstat, gmask;
    logic            irq_neoc, irq_nchain, irq_jeoc, irq_jchain, irq_any;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eoc_irq_agg #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .conv_done_i(conv_done), .conv_chan_i(conv_chan), .conv_inj_i(conv_inj),
        .nchain_done_i(nchain), .ichain_done_i(ichain),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .chan_pend_o(pend), .chan_mask_o(cmask),
        .glb_stat_o(gstat), .glb_mask_o(gmask),
        .irq_neoc_o(irq_neoc), .irq_nchain_o(irq_nchain),
        .irq_jeoc_o(irq_jeoc), .irq_jchain_o(irq_jchain), .irq_any_o(irq_any)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one-cycle write; returns at the negedge after the capturing edge
    task automatic do_wr(input logic [1:0] sel, input logic [NCH-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_conv(input int ch, input logic inj);
        @(negedge clk);
        conv_done = 1'b1; conv_chan = CH_W'(ch); conv_inj = inj;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic clear_all();
        do_wr(2'd1, '1);
        do_wr(2'd3, '1);
        do_wr(2'd0, '0);
        do_wr(2'd2, '0);
    endtask

    task automatic t_reset();
        chk("R1 pending", 64'(pend), 0);
        chk("R1 chan mask", 64'(cmask), 0);
        chk("R1 status", 64'(gstat), 0);
        chk("R1 glb mask", 64'(gmask), 0);
        chk("R1 irqs", 64'({irq_neoc, irq_nchain, irq_jeoc, irq_jchain, irq_any}), 0);
    endtask

    task automatic t_masks();
        do_wr(2'd0, 24'hA5_0F31);
        chk("R11 chan mask load", 64'(cmask), 64'h00A5_0F31);
        do_wr(2'd2, 24'h00_0006);
        chk("R11 glb mask load", 64'(gmask), 64'h6);
        do_wr(2'd0, '0);
        do_wr(2'd2, '0);
        chk("R11 masks cleared", 64'({cmask, gmask}), 0);
    endtask

    task automatic t_conv_set();
        clear_all();
        do_conv(3, 1'b0);
        chk("R2 normal pend ch3", 64'(pend), 64'h8);
        chk("R3 normal status", 64'(gstat), 64'h1);
        do_conv(23, 1'b1);
        chk("R2 inj pend ch23", 64'(pend), 64'h80_0008);
        chk("R3 inj status", 64'(gstat), 64'h5);
        clear_all();
        do_conv(24, 1'b0);
        do_conv(31, 1'b1);
        chk("R2 out of range pend", 64'(pend), 0);
        chk("R2 out of range status", 64'(gstat), 0);
    endtask

    task automatic t_chain();
        clear_all();
        @(negedge clk); nchain = 1'b1;
        @(negedge clk); nchain = 1'b0;
        chk("R4 normal chain", 64'(gstat), 64'h2);
        @(negedge clk); ichain = 1'b1;
        @(negedge clk); ichain = 1'b0;
        chk("R4 injected chain", 64'(gstat), 64'hA);
    endtask

    task automatic t_w1c();
        clear_all();
        do_conv(1, 1'b0);
        do_conv(2, 1'b1);
        do_conv(9, 1'b0);
        do_wr(2'd1, 24'h00_0204);
        chk("R5 pend partial clear", 64'(pend), 64'h2);
        do_wr(2'd3, 24'h00_0004);
        chk("R5 status partial clear", 64'(gstat), 64'h1);
    endtask

    task automatic t_set_wins();
        clear_all();
        do_conv(6, 1'b0);
        @(negedge clk);
        conv_done = 1'b1; conv_chan = CH_W'(6); conv_inj = 1'b0;
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 24'h00_0040;
        @(negedge clk);
        conv_done = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R6 pend set wins", 64'(pend), 64'h40);
        @(negedge clk);
        nchain = 1'b1;
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 24'h00_0003;
        @(negedge clk);
        nchain = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R6 status set wins, other cleared", 64'(gstat), 64'h2);
    endtask

    task automatic t_neoc_irq();
        clear_all();
        do_wr(2'd2, 24'h1);
        do_wr(2'd0, 24'h20);
        do_conv(4, 1'b0);
        chk("R7 unmasked channel no irq", 64'(irq_neoc), 0);
        do_conv(5, 1'b0);
        chk("R7 irq on qualified channel", 64'(irq_neoc), 1);
        chk("R10 any follows", 64'(irq_any), 1);
        do_wr(2'd2, 24'h0);
        chk("R7 global mask off", 64'(irq_neoc), 0);
        chk("R10 any low", 64'(irq_any), 0);
        do_wr(2'd2, 24'h1);
        do_wr(2'd1, 24'h20);
        chk("R7 pending cleared", 64'(irq_neoc), 0);
    endtask

    task automatic t_jeoc_irq();
        clear_all();
        do_wr(2'd2, 24'h5);
        do_wr(2'd0, 24'h80);
        do_conv(7, 1'b1);
        chk("R8 injected irq", 64'(irq_jeoc), 1);
        chk("R7 normal stays low", 64'(irq_neoc), 0);
        do_wr(2'd3, 24'h4);
        chk("R8 status cleared", 64'(irq_jeoc), 0);
    endtask

    task automatic t_chain_irq();
        clear_all();
        @(negedge clk); nchain = 1'b1; ichain = 1'b1;
        @(negedge clk); nchain = 1'b0; ichain = 1'b0;
        chk("R9 masked chain quiet", 64'({irq_nchain, irq_jchain, irq_any}), 0);
        do_wr(2'd2, 24'h8);
        chk("R9 injected chain irq", 64'({irq_nchain, irq_jchain}), 64'h1);
        chk("R10 any from chain", 64'(irq_any), 1);
        do_wr(2'd2, 24'h2);
        chk("R9 normal chain irq", 64'({irq_nchain, irq_jchain}), 64'h2);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all R) actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_conv_set();
        t_chain();
        t_w1c();
        t_set_wins();
        t_neoc_irq();
        t_jeoc_irq();
        t_chain_irq();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule